// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the device side of a small byte-wide serial memory that sits on a two-wire bus. Both bus lines arrive as plain inputs and are passed through two flip-flops into the system clock domain before any edge is looked at. The only bus output is an open-drain enable: when it is high the pad pulls the data line low, and otherwise the line floats high. The block finds start and stop conditions. It takes in a device byte, a word address and a data byte, and sends read bytes back. It acknowledges the bytes it accepts and holds a register array of configurable depth.

A write does not go to the array straight away. The received byte is kept in a staging register and written only when a stop condition closes the transfer. The write also moves the word pointer on, and it starts a timed write period counted in system clocks. A repeated start between an address phase and a read gives a random read. A read that is not preceded by an address continues from the current pointer.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A start condition is a high-to-low change of the data line while the clock line is high. It begins a new command at the device byte from any state, and it abandons a byte that is partly shifted in.
- R2: Bytes clocked on the bus without a preceding start get no acknowledge, and they change neither the array nor the write period.
- R3: Bits are taken on the clock's rising edge, most significant bit first. The device byte carries the 7-bit identity (default 1010000) in bits 7:1 and the direction in bit 0, where 1 means read. The word address is the low log2(DEPTH) bits of the address byte.
- R4: The acknowledge is sda_oe high from the falling clock edge after the eighth bit to the falling edge after the ninth. It is given to a matching device byte, to the address byte and to the first write data byte.
- R5: Read data is driven most significant bit first and changes only after a falling clock edge. The line is released for the ninth clock. A master acknowledge continues with the next word, and a master no-acknowledge ends the read.
- R6: A write byte reaches the array only when a stop follows it. A start that comes before the stop throws the byte away.
- R7: After the stop that commits a write, the device byte gets no acknowledge for WR_CYCLES system clocks. After that period it is acknowledged again.
- R8: A device byte with a different identity is not acknowledged, and the slave leaves the bus alone until the next start.
- R9: The word pointer moves up by one after each byte read or committed, and it wraps from DEPTH-1 to 0. A read with no address phase starts at the pointer.
- R10: A second data byte inside one write gets no acknowledge and is not stored.
- R11: While reset is asserted and after it is released, sda_oe is low, every array word is zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the data line, 1 drives low |

## Verification
A wrong bit counter or a wrong state shows up as an acknowledge pulse in the wrong clock, or a missing one. It appears within the same byte, at most nine bus clocks later. A corrupted pointer, staging register or array word stays hidden until the next read, where it comes back as wrong data bits on sda_oe. Because of this, every write is followed by a read of the affected words and of the word next to them. A fault in the write-period timer shows up on the first device byte sent after a committed write: either it is acknowledged too early, or it is refused after the period has run out.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDAT,
    ST_HOLD,
    ST_RDAT
  } twi_st_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] words_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic hit;
      assign hit = we && (addr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   words_q[g] <= 8'h00;
        else if (hit) words_q[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = words_q[addr];
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_ee_pkg::*;
#(
  parameter int         DEPTH     = 16,
  parameter int         WR_CYCLES = 400,
  parameter logic [6:0] DEV_ID    = 7'h50,
  parameter int         SYNC      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int            AW   = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic busy;
  logic [7:0] rdata;

  twi_st_e     st, st_n;
  logic [3:0]  bitcnt, bitcnt_n;
  logic [7:0]  sh, sh_n, tx, tx_n, stage, stage_n;
  logic [AW-1:0] ptr, ptr_n;
  logic        stage_v, stage_v_n, oe, oe_n, rd_go, rd_go_n, cmt, cmt_n;
  logic [2:0]  tx_idx;

  twi_line_sync #(.STAGES(SYNC)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .level_o(scl_s), .prev_o(scl_p)
  );
  twi_line_sync #(.STAGES(SYNC)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .level_o(sda_s), .prev_o(sda_p)
  );

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign tx_idx   = 3'd7 - bitcnt[2:0];

  twi_mem_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(cmt), .addr(ptr), .wdata(stage), .rdata(rdata)
  );

  twi_busy_timer #(.CYCLES(WR_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(cmt), .busy(busy)
  );

  always_comb begin
    st_n      = st;
    bitcnt_n  = bitcnt;
    sh_n      = sh;
    tx_n      = tx;
    stage_n   = stage;
    stage_v_n = stage_v;
    ptr_n     = ptr;
    oe_n      = oe;
    rd_go_n   = rd_go;
    cmt_n     = 1'b0;
    if (cmt) ptr_n = (ptr == LAST) ? '0 : ptr + 1'b1;
    if (start_ev) begin
      st_n      = ST_DEV;
      bitcnt_n  = '0;
      oe_n      = 1'b0;
      stage_v_n = 1'b0;
    end else if (stop_ev) begin
      st_n     = ST_IDLE;
      bitcnt_n = '0;
      oe_n     = 1'b0;
      if (stage_v) begin
        cmt_n     = 1'b1;
        stage_v_n = 1'b0;
      end
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          sh_n     = {sh[6:0], sda_s};
          bitcnt_n = bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt_n = 4'd9;
          if (st == ST_RDAT) begin
            ptr_n   = (ptr == LAST) ? '0 : ptr + 1'b1;
            rd_go_n = ~sda_s;
          end
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            ST_DEV: begin
              if (sh[7:1] == DEV_ID && !busy) oe_n = 1'b1;
              else                            st_n = ST_IDLE;
            end
            ST_ADDR: begin
              oe_n  = 1'b1;
              ptr_n = sh[AW-1:0];
            end
            ST_WDAT: begin
              oe_n      = 1'b1;
              stage_n   = sh;
              stage_v_n = 1'b1;
            end
            ST_RDAT: oe_n = 1'b0;
            default: oe_n = 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt_n = '0;
          oe_n     = 1'b0;
          case (st)
            ST_DEV: begin
              if (sh[0]) begin
                st_n = ST_RDAT;
                tx_n = rdata;
                oe_n = ~rdata[7];
              end else begin
                st_n = ST_ADDR;
              end
            end
            ST_ADDR: st_n = ST_WDAT;
            ST_WDAT: st_n = ST_HOLD;
            ST_RDAT: begin
              if (rd_go) begin
                tx_n = rdata;
                oe_n = ~rdata[7];
              end else begin
                st_n = ST_IDLE;
              end
            end
            default: st_n = st;
          endcase
        end else if (st == ST_RDAT && bitcnt != 4'd0) begin
          oe_n = ~tx[tx_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      sh      <= '0;
      tx      <= '0;
      stage   <= '0;
      stage_v <= 1'b0;
      ptr     <= '0;
      oe      <= 1'b0;
      rd_go   <= 1'b0;
      cmt     <= 1'b0;
    end else begin
      st      <= st_n;
      bitcnt  <= bitcnt_n;
      sh      <= sh_n;
      tx      <= tx_n;
      stage   <= stage_n;
      stage_v <= stage_v_n;
      ptr     <= ptr_n;
      oe      <= oe_n;
      rd_go   <= rd_go_n;
      cmt     <= cmt_n;
    end
  end

  assign sda_oe = oe;
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk
  import twi_ee_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       busy,
  input logic       cmt,
  input logic [3:0] bitcnt,
  input twi_st_e    st
);
  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev)); // R5
  AST_START_RESTARTS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bitcnt == 4'd0 && st == ST_DEV)); // R1
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmt |-> $past(stop_ev)); // R6
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmt)); // R7
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_DEV) |-> !sda_oe); // R7
  AST_IDLE_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R8
endmodule

bind twi_eeprom_slave twi_eeprom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .busy(busy), .cmt(cmt),
  .bitcnt(bitcnt), .st(st)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb_top;
  localparam int H   = 16;
  localparam int WR  = 400;
  localparam int DEP = 16;

  logic clk;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe;
  logic sda_bus;
  int   n_chk, n_fail, cyc;
  logic win, exp_oe;
  string req;
  logic [7:0] model_mem [DEP];

  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_slave #(.DEPTH(DEP), .WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference comparison on every clock inside a settled bus phase
  always @(negedge clk) begin
    if (win) begin
      n_chk++;
      if (sda_oe !== exp_oe) begin
        n_fail++;
        $display("FAIL %s sda_oe actual %0b expected %0b at %0t", req, sda_oe, exp_oe, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic phase(input logic e, input string r);
    wclk(4);
    exp_oe = e;
    req = r;
    win = 1'b1;
    wclk(H - 4);
    win = 1'b0;
  endtask

  task automatic bit_x(input logic b, input logic e, input string r);
    wclk(2);
    sda_m = b;
    phase(e, r);
    scl_m = 1'b1;
    phase(e, r);
    scl_m = 1'b0;
  endtask

  task automatic bus_start(input string r);
    wclk(2);
    sda_m = 1'b1;
    wclk(2);
    scl_m = 1'b1;
    phase(1'b0, r);
    sda_m = 1'b0;
    phase(1'b0, r);
    scl_m = 1'b0;
    wclk(2);
  endtask

  task automatic bus_stop(input string r);
    wclk(2);
    sda_m = 1'b0;
    phase(1'b0, r);
    scl_m = 1'b1;
    phase(1'b0, r);
    sda_m = 1'b1;
    phase(1'b0, r);
  endtask

  // R3: MSB first; R4: ack on ninth clock when expected
  task automatic send_byte(input logic [7:0] b, input logic ack, input string r);
    for (int i = 7; i >= 0; i--) bit_x(b[i], 1'b0, r);
    bit_x(1'b1, ack, r);
  endtask

  // R5: read bits appear as pull-downs, ninth clock released
  task automatic recv_byte(input logic [7:0] b, input logic mack, input string r);
    for (int i = 7; i >= 0; i--) bit_x(1'b1, ~b[i], r);
    bit_x(~mack, 1'b0, r);
  endtask

  task automatic write_word(input logic [3:0] a, input logic [7:0] d);
    bus_start("R1");
    send_byte(8'hA0, 1'b1, "R4");
    send_byte({4'h0, a}, 1'b1, "R4");
    send_byte(d, 1'b1, "R4");
    bus_stop("R6");
    model_mem[a] = d;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    win = 1'b0; exp_oe = 1'b0; req = "R11";
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < DEP; i++) model_mem[i] = 8'h00;
    wclk(5);
    n_chk++;
    if (sda_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 sda_oe in reset actual %0b expected 0", sda_oe);
    end
    rst_n = 1'b1;
    phase(1'b0, "R11");

    // R2: bytes with no start: no ack, nothing staged
    scl_m = 1'b0;
    send_byte(8'hA0, 1'b0, "R2");
    send_byte(8'h03, 1'b0, "R2");
    send_byte(8'h99, 1'b0, "R2");
    bus_stop("R2");
    // R2/R7: no write period was started, so device byte is acknowledged at once
    bus_start("R2");
    send_byte(8'hA1, 1'b1, "R2");
    recv_byte(model_mem[0], 1'b0, "R11");   // R11 array and pointer zero
    bus_stop("R2");

    // R6/R7: committed write, then refused during the write period
    write_word(4'd3, 8'hA5);
    bus_start("R7");
    send_byte(8'hA0, 1'b0, "R7");
    bus_stop("R7");
    wclk(WR + 50);
    // R3/R5 random read via repeated start
    bus_start("R1");
    send_byte(8'hA0, 1'b1, "R7");
    send_byte(8'h03, 1'b1, "R4");
    bus_start("R1");
    send_byte(8'hA1, 1'b1, "R4");
    recv_byte(model_mem[3], 1'b1, "R5");
    recv_byte(model_mem[4], 1'b0, "R5");
    bus_stop("R5");

    // R6: repeated start before stop discards the staged byte
    bus_start("R6");
    send_byte(8'hA0, 1'b1, "R6");
    send_byte(8'h05, 1'b1, "R6");
    send_byte(8'h3C, 1'b1, "R6");
    bus_start("R6");
    send_byte(8'hA1, 1'b1, "R6");
    recv_byte(model_mem[5], 1'b0, "R6");
    bus_stop("R6");

    // R8: foreign identity ignored until next start
    bus_start("R8");
    send_byte(8'hA2, 1'b0, "R8");
    send_byte(8'h00, 1'b0, "R8");
    bus_stop("R8");

    // R1: start in the middle of a byte abandons it
    bus_start("R1");
    bit_x(1'b1, 1'b0, "R1");
    bit_x(1'b0, 1'b0, "R1");
    bit_x(1'b1, 1'b0, "R1");
    bit_x(1'b0, 1'b0, "R1");
    bus_start("R1");
    send_byte(8'hA0, 1'b1, "R1");
    send_byte(8'h03, 1'b1, "R1");
    bus_start("R1");
    send_byte(8'hA1, 1'b1, "R1");
    recv_byte(model_mem[3], 1'b0, "R1");
    bus_stop("R1");

    // R10: second data byte refused, only first stored
    bus_start("R10");
    send_byte(8'hA0, 1'b1, "R10");
    send_byte(8'h07, 1'b1, "R10");
    send_byte(8'h5A, 1'b1, "R10");
    send_byte(8'h77, 1'b0, "R10");
    bus_stop("R10");
    model_mem[7] = 8'h5A;
    wclk(WR + 50);
    bus_start("R10");
    send_byte(8'hA1, 1'b1, "R9");           // R9 pointer now 8
    recv_byte(model_mem[8], 1'b0, "R10");
    bus_stop("R10");
    bus_start("R10");
    send_byte(8'hA0, 1'b1, "R10");
    send_byte(8'h07, 1'b1, "R10");
    bus_start("R10");
    send_byte(8'hA1, 1'b1, "R10");
    recv_byte(model_mem[7], 1'b1, "R10");
    recv_byte(model_mem[8], 1'b0, "R10");
    bus_stop("R10");

    // R9: wrap of pointer after write and after read
    write_word(4'd0, 8'h22);
    wclk(WR + 50);
    write_word(4'd15, 8'h11);
    wclk(WR + 50);
    bus_start("R9");
    send_byte(8'hA1, 1'b1, "R9");
    recv_byte(model_mem[0], 1'b0, "R9");
    bus_stop("R9");
    bus_start("R9");
    send_byte(8'hA0, 1'b1, "R9");
    send_byte(8'h0F, 1'b1, "R9");
    bus_start("R9");
    send_byte(8'hA1, 1'b1, "R9");
    recv_byte(model_mem[15], 1'b1, "R9");
    recv_byte(model_mem[0], 1'b1, "R9");
    recv_byte(model_mem[1], 1'b0, "R9");
    bus_stop("R9");

    wclk(10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule